// File: doc/BRIEF.md
# Slow Serial Control Packet Decoder

This block watches a single control line whose value changes at one eighth of the core clock rate. It samples the line once every eight core clocks and sets two internal control flags. The "no data in" flag tells the surrounding logic to apply backpressure on every input at every priority. The "no data out" flag makes the surrounding logic act as if every output were backpressured. The logic that acts on these flags lies outside this block.

A mode input selects how the flags are set. In packet mode the line rests at 0. A packet starts with a rising edge that comes after a run of idle zeros and lasts eleven bit-times. It is accepted only if its first three bits are 1,0,0. Its fourth and fifth bits give the new values of the two flags, and its last six bits carry nothing. A packet with a wrong header is skipped as a whole. A rising edge that comes too soon after the previous packet does not start a packet. Each rejected packet and each early edge adds one to a saturating error count. In direct mode no framing is done, and each sample of the line becomes the "no data out" flag.

Top module: `serial_ctl_decoder`

## Requirements
- R1: The line is sampled on every eighth rising clock edge. The phase is set by a counter that starts at reset, so the first sample falls on the eighth edge after reset is released. The flags and the error count change only on sampling edges.
- R2: A synchronous active-low reset clears both flags and the error count. After reset the line is treated as having been high, so four zero samples are needed before the first packet.
- R3: In packet mode, a sample of 1 whose previous sample was 0 starts a packet only if at least four consecutive zero samples came before it. These zeros are counted since reset, since the end of the last packet or since the return to packet mode.
- R4: A packet is eleven samples long, numbered 0 to 10. Samples 0 to 2 must read 1,0,0. Sample 3 becomes the "no data in" flag and sample 4 becomes the "no data out" flag. Samples 5 to 10 are ignored. Both flags are updated together on the sampling edge of sample 10.
- R5: Neither flag changes while a packet is still being received, before its sample 10.
- R6: If sample 1 or sample 2 differs from 0, all eleven samples are still taken, whatever their values. The flags keep their values, and the error count rises by one on the edge of sample 10.
- R7: A rising edge that comes after fewer than four zero samples does not start a packet. The error count rises by one on that sample, and the zero run starts again from nothing.
- R8: In direct mode (mode input 0), every sample is copied to the "no data out" flag and the "no data in" flag holds its value. Any packet in progress is abandoned. On return to packet mode the line is treated as high, so four zeros are needed again.
- R9: The error count stops at its largest value, 2^CNT_W-1, and does not wrap.
- R10: Outside a packet, a sample of 1 that follows a sample of 1 is neither a packet start nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_mode | input | 1 | 1: packet mode, 0: direct mode |
| ser_in | input | 1 | Slow serial control line |
| no_in_flag | output | 1 | Registered "no data in" flag (global input backpressure) |
| no_out_flag | output | 1 | Registered "no data out" flag (treat all outputs as backpressured) |
| bad_pkt_cnt | output | CNT_W | Saturating count of bad headers and early edges |

## Verification
The decoder is given valid packets with each combination of the two flag bits, with ones placed in the ignored tail. This shows that only samples 3 and 4 are used and that both flags land together on the eleventh sample. Gaps of exactly three and exactly four zeros fall on either side of the start rule. Headers with a wrong second bit and with a wrong third bit are sent with rising edges inside them, which shows that a rejected packet still takes eleven bit-times. A held-high line, a switch to direct mode and back, and a burst of early edges show the difference between no event and an error, and show that the count saturates.

// File: rtl/scd_pkg.sv
// Shared types for the slow serial control packet decoder.
package scd_pkg;

    // Framer state: waiting for a packet start, or collecting packet samples.
    typedef enum logic [0:0] {
        FR_IDLE = 1'b0,
        FR_RECV = 1'b1
    } fr_state_t;

endpackage

// File: rtl/scd_tick_gen.sv
// Sample-strobe generator.
// Gives a one-cycle strobe on every DIV-th clock. The phase is fixed by reset,
// and the first strobe comes on the DIV-th edge after reset is released.
// Assumes DIV >= 2.
module scd_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] div_cnt;

    assign tick = (div_cnt == CW'(DIV - 1));

    // Free-running divide-by-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scd_framer.sv
// Packet framer.
// Looks for a rising edge that comes after at least GAP zero samples, then takes
// PKT_LEN samples. It checks the first HDR_LEN samples against HDR_CODE (MSB
// first) and captures the two flag bits that follow the header.
// Assumes HDR_LEN + 2 < PKT_LEN and that HDR_CODE has a 1 in its MSB.
// When enable is low, the framer is held idle with the line treated as high.
module scd_framer
    import scd_pkg::*;
#(
    parameter int                 PKT_LEN  = 11,
    parameter int                 HDR_LEN  = 3,
    parameter logic [HDR_LEN-1:0] HDR_CODE = 3'b100,
    parameter int                 GAP      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic ser_in,
    output logic pkt_done,
    output logic pkt_good,
    output logic bit_a,
    output logic bit_b,
    output logic early_edge
);
    localparam int IDX_W = $clog2(PKT_LEN);
    localparam int GAP_W = $clog2(GAP + 1);
    localparam int A_POS = HDR_LEN;
    localparam int B_POS = HDR_LEN + 1;

    fr_state_t        state;
    logic [IDX_W-1:0] idx;
    logic [GAP_W-1:0] zero_run;
    logic             prev;
    logic             hdr_bad;
    logic             cap_a;
    logic             cap_b;
    logic             hdr_mis;
    logic             rise;
    logic             gap_ok;
    logic             last_bit;

    assign rise     = ser_in & ~prev;
    assign gap_ok   = (zero_run >= GAP_W'(GAP));
    assign last_bit = (state == FR_RECV) && (idx == IDX_W'(PKT_LEN - 1));

    // Flags a header sample that does not match the expected code.
    always_comb begin
        hdr_mis = 1'b0;
        for (int i = 0; i < HDR_LEN; i++) begin
            if (state == FR_RECV && idx == IDX_W'(i) && ser_in != HDR_CODE[HDR_LEN-1-i]) begin
                hdr_mis = 1'b1;
            end
        end
    end

    assign pkt_done   = tick & enable & last_bit;
    assign pkt_good   = ~(hdr_bad | hdr_mis);
    assign bit_a      = cap_a;
    assign bit_b      = cap_b;
    assign early_edge = tick & enable & (state == FR_IDLE) & rise & ~gap_ok;

    // Framing state machine, advanced once per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state    <= FR_IDLE;
            idx      <= '0;
            zero_run <= '0;
            prev     <= 1'b1;
            hdr_bad  <= 1'b0;
            cap_a    <= 1'b0;
            cap_b    <= 1'b0;
        end else if (tick) begin
            case (state)
                FR_IDLE: begin
                    prev <= ser_in;
                    if (ser_in) begin
                        zero_run <= '0;
                    end else if (!gap_ok) begin
                        zero_run <= zero_run + 1'b1;
                    end
                    if (rise && gap_ok) begin
                        state   <= FR_RECV;
                        idx     <= IDX_W'(1);
                        hdr_bad <= 1'b0;
                    end
                end
                default: begin
                    if (hdr_mis) begin
                        hdr_bad <= 1'b1;
                    end
                    if (idx == IDX_W'(A_POS)) begin
                        cap_a <= ser_in;
                    end
                    if (idx == IDX_W'(B_POS)) begin
                        cap_b <= ser_in;
                    end
                    if (last_bit) begin
                        state    <= FR_IDLE;
                        idx      <= '0;
                        zero_run <= '0;
                        prev     <= ser_in;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/scd_err_counter.sv
// Saturating error counter.
// Adds one on each cycle where inc is high, and stops at all-ones.
module scd_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Counts up until the count is all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && count != '1) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/serial_ctl_decoder.sv
// Slow serial control packet decoder (top).
// Samples a line that changes at 1/DIV of the clock rate. In packet mode it
// sets two flags from framed packets. In direct mode it copies each sample to
// the "no data out" flag. It counts bad headers and early edges.
// Assumes that ser_in is already synchronous to clk.
module serial_ctl_decoder #(
    parameter int DIV     = 8,
    parameter int PKT_LEN = 11,
    parameter int GAP     = 4,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_mode,
    input  logic             ser_in,
    output logic             no_in_flag,
    output logic             no_out_flag,
    output logic [CNT_W-1:0] bad_pkt_cnt
);
    logic tick;
    logic pkt_done;
    logic pkt_good;
    logic bit_a;
    logic bit_b;
    logic early_edge;
    logic err_inc;

    scd_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    scd_framer #(
        .PKT_LEN (PKT_LEN),
        .HDR_LEN (3),
        .HDR_CODE(3'b100),
        .GAP     (GAP)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (pkt_mode),
        .ser_in    (ser_in),
        .pkt_done  (pkt_done),
        .pkt_good  (pkt_good),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .early_edge(early_edge)
    );

    assign err_inc = early_edge | (pkt_done & ~pkt_good);

    scd_err_counter #(.CNT_W(CNT_W)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (err_inc),
        .count(bad_pkt_cnt)
    );

    // Flag registers: set from the line in direct mode, or from a good packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_in_flag  <= 1'b0;
            no_out_flag <= 1'b0;
        end else if (tick) begin
            if (!pkt_mode) begin
                no_out_flag <= ser_in;
            end else if (pkt_done && pkt_good) begin
                no_in_flag  <= bit_a;
                no_out_flag <= bit_b;
            end
        end
    end
endmodule

// File: rtl/scd_checker.sv
// Property checker for serial_ctl_decoder, attached with bind.
module scd_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_mode,
    input logic             tick,
    input logic             no_in_flag,
    input logic             no_out_flag,
    input logic [CNT_W-1:0] bad_pkt_cnt
);
    // R1
    sample_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R1
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(no_in_flag) && $stable(no_out_flag)));

    // R1
    cnt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(bad_pkt_cnt));

    // R8
    no_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pkt_mode) |-> $stable(no_in_flag));

    // R6 R7
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bad_pkt_cnt) |-> (bad_pkt_cnt - $past(bad_pkt_cnt)) == CNT_W'(1));

    // R9
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&bad_pkt_cnt) |=> (&bad_pkt_cnt));
endmodule

bind serial_ctl_decoder scd_checker #(.CNT_W(CNT_W)) u_scd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_mode   (pkt_mode),
    .tick       (tick),
    .no_in_flag (no_in_flag),
    .no_out_flag(no_out_flag),
    .bad_pkt_cnt(bad_pkt_cnt)
);

// File: tb/serial_ctl_decoder_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// scenario checks tied to the requirements.
module serial_ctl_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;
    localparam int CMAX       = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_mode = 1'b1;
    logic          ser_in = 1'b0;
    logic          no_in_flag;
    logic          no_out_flag;
    logic [CW-1:0] bad_pkt_cnt;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    int m_div, m_zeros, m_err;
    bit m_in, m_out, m_prev, m_busy;
    bit m_q[$];

    serial_ctl_decoder #(.CNT_W(CW)) u_serial_ctl_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_mode   (pkt_mode),
        .ser_in     (ser_in),
        .no_in_flag (no_in_flag),
        .no_out_flag(no_out_flag),
        .bad_pkt_cnt(bad_pkt_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic model_sample(input bit s);
        if (!pkt_mode) begin
            m_out = s; m_busy = 0; m_zeros = 0; m_prev = 1; m_q.delete();
        end else if (m_busy) begin
            m_q.push_back(s);
            if (m_q.size() == 11) begin
                if (m_q[0] == 1 && m_q[1] == 0 && m_q[2] == 0) begin
                    m_in = m_q[3]; m_out = m_q[4];
                end else if (m_err < CMAX) m_err++;
                m_busy = 0; m_zeros = 0; m_prev = s; m_q.delete();
            end
        end else begin
            if (s && !m_prev) begin
                if (m_zeros >= 4) begin
                    m_busy = 1; m_q.delete(); m_q.push_back(s);
                end else if (m_err < CMAX) m_err++;
            end
            if (s) m_zeros = 0; else m_zeros++;
            m_prev = s;
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_zeros = 0; m_err = 0; m_in = 0; m_out = 0;
            m_prev = 1; m_busy = 0; m_q.delete();
        end else if (m_div == 7) begin
            m_div = 0;
            model_sample(ser_in);
        end else begin
            m_div++;
        end
    end

    // Compares the design with the model once per clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (no_in_flag !== m_in || no_out_flag !== m_out || int'(bad_pkt_cnt) != m_err) begin
                errors++;
                $display("FAIL R1 model mismatch t=%0t: in=%b out=%b cnt=%0d expected in=%b out=%b cnt=%0d",
                         $time, no_in_flag, no_out_flag, bad_pkt_cnt, m_in, m_out, m_err);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input bit b);
        ser_in = b;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    // Sends the first n bits of an 11-bit word, MSB first.
    task automatic send_word(input logic [10:0] w, input int n);
        for (int i = 10; i > 10 - n; i--) send_bit(w[i]);
    endtask

    task automatic chk_state(input string tag, input int e_in, input int e_out, input int e_cnt);
        chk({tag, " no_in"}, int'(no_in_flag), e_in);
        chk({tag, " no_out"}, int'(no_out_flag), e_out);
        chk({tag, " count"}, int'(bad_pkt_cnt), e_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R2: reset state
        chk_state("R2 reset", 0, 0, 0);
        // R1: seven edges after release, no sample has been taken yet
        ser_in = 1'b1;
        repeat (7) @(negedge clk);
        ser_in = 1'b0;
        repeat (9) @(negedge clk);
        chk("R1 first sample phase count", int'(bad_pkt_cnt), 0);

        // R4 R5: valid packet, no_in=1 no_out=0, ones in the tail
        send_zeros(4);
        send_word(11'b100_10_111111, 10);
        chk_state("R5 before sample 10", 0, 0, 0);
        send_bit(1'b1);
        chk_state("R4 packet a", 1, 0, 0);

        // R4: no_in=0 no_out=1
        send_zeros(4);
        send_word(11'b100_01_000000, 11);
        chk_state("R4 packet b", 0, 1, 0);

        // R7: only three zeros before the edge
        send_zeros(3);
        send_bit(1'b1);
        chk_state("R7 early edge", 0, 1, 1);
        // R10: line held high
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        chk_state("R10 held high", 0, 1, 1);
        // R3: exactly four zeros are enough
        send_zeros(4);
        send_word(11'b100_11_010101, 11);
        chk_state("R3 four zero gap", 1, 1, 1);

        // R6: wrong second header bit, with edges inside
        send_zeros(5);
        send_word(11'b110_00_101000, 11);
        chk_state("R6 bad header bit1", 1, 1, 2);
        send_zeros(4);
        send_word(11'b100_00_000000, 11);
        chk_state("R6 next packet accepted", 0, 0, 2);
        // R6: wrong third header bit
        send_zeros(4);
        send_word(11'b101_11_000000, 11);
        chk_state("R6 bad header bit2", 0, 0, 3);

        // R8: direct mode
        send_zeros(4);
        send_word(11'b100_10_000000, 11);
        chk_state("R4 packet c", 1, 0, 3);
        pkt_mode = 1'b0;
        send_bit(1'b1);
        chk_state("R8 direct high", 1, 1, 3);
        send_bit(1'b0);
        chk_state("R8 direct low", 1, 0, 3);
        pkt_mode = 1'b1;
        send_zeros(2);
        send_bit(1'b1);
        chk_state("R8 regap required", 1, 0, 4);
        send_zeros(4);
        send_word(11'b100_01_000000, 11);
        chk_state("R8 packet after return", 0, 1, 4);

        // R9: saturation
        send_bit(1'b0);
        for (int i = 0; i < 14; i++) begin
            send_bit(1'b1);
            send_bit(1'b0);
        end
        chk("R9 saturated count", int'(bad_pkt_cnt), CMAX);
        chk("R9 flags kept", int'(no_out_flag), 1);

        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule